// File: doc/BRIEF.md
# Folded-Coefficient Decimating FIR Filter

This block is a linear-phase low-pass FIR filter for a stream of signed 16-bit samples. It produces one output for every D accepted samples. The impulse response is assumed symmetric, so only the first half of the coefficients is stored. Each multiply works on the sum of two mirrored delay-line samples. A single multiply-accumulate engine runs on the system clock, which is faster than the sample rate, and spends ceil(N/2) cycles on each output. Samples arrive as single-cycle `in_valid` strobes.

Software sets the tap count, the decimation factor, a bypass switch and the coefficient memory through a 16-bit write port. Results are 24-bit words, rounded and saturated from a wide accumulator. Each result is marked by a one-cycle `out_valid` pulse. A sticky `overrun` flag reports a sample that arrived while a computation was still pending.

Top module: `fir_symdec`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line, the decimation phase, the accumulator, `out_valid`, `out_data` and `overrun`. It sets the tap count to 1, the decimation factor to 1 and bypass off. The stored coefficients are left unchanged.
- R2: The two top bits of `wr_addr` select a region and the low 5 bits give an index k. Region 2'b10 stages a low coefficient word. Region 2'b11 commits coefficient k as {wr_data[3:0], staged low word}. A low-word write alone does not change the coefficient in use.
- R3: Region 2'b00 holds the configuration. Index 0 sets the tap count N from wr_data[9:0], valid range 1 to MAX_TAPS. Index 1 takes D-1 in wr_data[3:0], so D runs from 1 to 16. Index 2 sets bypass from wr_data[0].
- R4: Each output equals sum over i from 0 to N-1 of h(i)*x[n-i], where x[n] is the newest accepted sample, h(i) = c[min(i, N-1-i)] and c[k] is stored coefficient k. Delay-line positions never written since reset count as zero.
- R5: For odd N the centre coefficient multiplies its single sample once. For even N every coefficient weights exactly two samples.
- R6: With bypass off, outputs are produced after accepted samples number D, 2D, 3D and so on, counted from reset.
- R7: If the D-th sample is captured at clock edge T, `out_valid` is high for exactly the one cycle after edge T+ceil(N/2)+1.
- R8: `out_data` equals floor((acc + 2^14) / 2^15), clamped to the range -2^23 to 2^23-1. Coefficients therefore carry 15 fraction bits.
- R9: With bypass on, each `in_valid` gives `out_valid` one cycle later with `out_data` equal to the sign-extended sample. The delay line and the decimation phase are left untouched.
- R10: A filtered sample accepted while a computation is still pending sets `overrun`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe of the configuration port |
| wr_addr | input | 7 | Region (top 2 bits) and index |
| wr_data | input | 16 | Write data |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 24 | Signed filtered or bypassed result |
| overrun | output | 1 | Sticky pending-computation overrun flag |

## Verification
Several properties are checked on every cycle by assertions:
- the engine's tap index stays inside the folded range;
- a start is followed by a fresh accumulation;
- the engine's result strobe lasts one cycle;
- bypass returns the sign-extended sample one cycle later;
- `overrun` stays set once raised.

Other behaviours need the bench's scenarios and its reference model:
- the arithmetic of the folded sums for odd and even tap counts;
- decimation phasing;
- rounding and saturation;
- keeping the delay line across bypass;
- retaining coefficients across reset;
- the staged-commit rule of the write port.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int DATA_W = 16;
    localparam int COEF_W = 20;
    localparam int OUT_W  = 24;
    localparam int ACC_W  = 48;
    localparam int BUS_W  = 16;
    localparam int FRAC   = 15;
    localparam int CNT_W  = 10;

    typedef logic signed [DATA_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [OUT_W-1:0]  out_t;

    typedef enum logic [1:0] {
        RG_CFG  = 2'b00,
        RG_RSVD = 2'b01,
        RG_CLO  = 2'b10,
        RG_CHI  = 2'b11
    } region_e;

    typedef struct packed {
        logic [CNT_W-1:0] taps;
        logic [3:0]       dm1;
        logic             bypass;
    } cfg_t;

    localparam acc_t OUT_MAX = acc_t'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam acc_t OUT_MIN = -OUT_MAX - acc_t'(1);

    function automatic out_t round_sat(acc_t a);
        acc_t r;
        r = (a + (acc_t'(1) <<< (FRAC-1))) >>> FRAC;
        if (r > OUT_MAX) return out_t'(OUT_MAX);
        if (r < OUT_MIN) return out_t'(OUT_MIN);
        return out_t'(r);
    endfunction
endpackage

// File: rtl/fir_cfg_regs.sv
module fir_cfg_regs
    import fir_pkg::*;
#(
    parameter int MAX_TAPS = 64,
    localparam int HALF   = (MAX_TAPS + 1) / 2,
    localparam int HIDX   = $clog2(HALF),
    localparam int ADDR_W = HIDX + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output cfg_t              cfg,
    input  logic [HIDX-1:0]   rd_idx,
    output coef_t             rd_coef
);
    region_e          rg;
    logic [HIDX-1:0]  widx;
    logic [BUS_W-1:0] lo_q;
    coef_t            mem [HALF];

    assign rg   = region_e'(wr_addr[ADDR_W-1 -: 2]);
    assign widx = wr_addr[HIDX-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{taps: CNT_W'(1), dm1: 4'd0, bypass: 1'b0};
        end else if (wr_en && rg == RG_CFG) begin
            case (widx[1:0])
                2'd0:    cfg.taps   <= wr_data[CNT_W-1:0];
                2'd1:    cfg.dm1    <= wr_data[3:0];
                2'd2:    cfg.bypass <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Coefficient store and staging word are not reset.
    always_ff @(posedge clk) begin
        if (wr_en && rg == RG_CLO) lo_q <= wr_data;
        if (wr_en && rg == RG_CHI) mem[widx] <= {wr_data[COEF_W-BUS_W-1:0], lo_q};
    end

    assign rd_coef = mem[rd_idx];

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rg == RG_CFG) |=> $stable(cfg));
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line
    import fir_pkg::*;
#(
    parameter int MAX_TAPS = 64,
    localparam int AW = $clog2(MAX_TAPS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift,
    input  samp_t         din,
    input  logic [AW-1:0] idx_a,
    input  logic [AW-1:0] idx_b,
    output samp_t         dout_a,
    output samp_t         dout_b
);
    logic [MAX_TAPS-1:0][DATA_W-1:0] line;

    always_ff @(posedge clk) begin
        if (rst)        line <= '0;
        else if (shift) line <= {line[MAX_TAPS-2:0], din};
    end

    assign dout_a = samp_t'(line[idx_a]);
    assign dout_b = samp_t'(line[idx_b]);
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_pkg::*;
#(
    parameter int MAX_TAPS = 64,
    localparam int AW   = $clog2(MAX_TAPS),
    localparam int HIDX = $clog2((MAX_TAPS + 1) / 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] n_taps,
    input  samp_t            xa,
    input  samp_t            xb,
    input  coef_t            h,
    output logic [AW-1:0]    idx_a,
    output logic [AW-1:0]    idx_b,
    output logic [HIDX-1:0]  cidx,
    output logic             busy_o,
    output logic             out_valid,
    output out_t             out_data
);
    logic                             busy, fin, last, centre;
    logic [CNT_W-1:0]                 k, kb, half;
    acc_t                             acc;
    logic signed [DATA_W:0]           pre;
    logic signed [DATA_W+COEF_W:0]    prod;

    assign half   = (n_taps + CNT_W'(1)) >> 1;
    assign kb     = n_taps - CNT_W'(1) - k;
    assign idx_a  = k[AW-1:0];
    assign idx_b  = kb[AW-1:0];
    assign cidx   = k[HIDX-1:0];
    assign centre = (kb == k);
    assign last   = (k == half - CNT_W'(1));
    assign busy_o = busy | fin;

    always_comb begin
        if (centre) pre = $signed({xa[DATA_W-1], xa});
        else        pre = $signed({xa[DATA_W-1], xa}) + $signed({xb[DATA_W-1], xb});
        prod = pre * h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; fin <= 1'b0; k <= '0; acc <= '0;
            out_valid <= 1'b0; out_data <= '0;
        end else begin
            out_valid <= 1'b0;
            fin       <= 1'b0;
            if (start) begin
                busy <= 1'b1; k <= '0; acc <= '0;
            end else if (busy) begin
                acc <= acc + acc_t'(prod);
                k   <= k + CNT_W'(1);
                if (last) begin
                    busy <= 1'b0; fin <= 1'b1;
                end
            end
            if (fin) begin
                out_valid <= 1'b1;
                out_data  <= round_sat(acc);
            end
        end
    end

    p_k_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (k < half));
    p_start_clear_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && k == '0 && acc == '0));
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

// File: rtl/fir_symdec.sv
module fir_symdec
    import fir_pkg::*;
#(
    parameter int MAX_TAPS = 64,
    localparam int AW     = $clog2(MAX_TAPS),
    localparam int HIDX   = $clog2((MAX_TAPS + 1) / 2),
    localparam int ADDR_W = HIDX + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic              overrun
);
    cfg_t            cfg;
    coef_t           h;
    samp_t           xa, xb;
    logic [AW-1:0]   idx_a, idx_b;
    logic [HIDX-1:0] cidx;
    logic            eng_busy, eng_v, take, start, byp_v;
    out_t            eng_d, byp_d;
    logic [3:0]      phase;

    assign take  = in_valid & ~cfg.bypass;
    assign start = take & (phase == cfg.dm1);

    fir_cfg_regs #(.MAX_TAPS(MAX_TAPS)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg(cfg), .rd_idx(cidx), .rd_coef(h));

    fir_delay_line #(.MAX_TAPS(MAX_TAPS)) u_line (
        .clk(clk), .rst(rst), .shift(take), .din(samp_t'(in_data)),
        .idx_a(idx_a), .idx_b(idx_b), .dout_a(xa), .dout_b(xb));

    fir_mac_engine #(.MAX_TAPS(MAX_TAPS)) u_mac (
        .clk(clk), .rst(rst), .start(start), .n_taps(cfg.taps),
        .xa(xa), .xb(xb), .h(h), .idx_a(idx_a), .idx_b(idx_b), .cidx(cidx),
        .busy_o(eng_busy), .out_valid(eng_v), .out_data(eng_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0; overrun <= 1'b0; byp_v <= 1'b0; byp_d <= '0;
        end else begin
            byp_v <= in_valid & cfg.bypass;
            if (in_valid && cfg.bypass) byp_d <= out_t'(samp_t'(in_data));
            if (take) phase <= start ? 4'd0 : phase + 4'd1;
            if (take && eng_busy) overrun <= 1'b1;
        end
    end

    assign out_valid = eng_v | byp_v;
    assign out_data  = byp_v ? byp_d : eng_d;

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    p_bypass_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.bypass) |=>
            (out_valid && out_data == {{(OUT_W-DATA_W){$past(in_data[DATA_W-1])}}, $past(in_data)}));
endmodule

// File: tb/tb_fir_symdec.sv
module tb_fir_symdec;
    localparam int MAXT = 64;
    logic        clk = 1'b0, rst = 1'b0, wr_en = 1'b0, in_valid = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0, in_data = '0;
    logic        out_valid, overrun;
    logic [23:0] out_data;

    fir_symdec #(.MAX_TAPS(MAXT)) dut (.*);

    always #2 clk = ~clk;

    int  ntests = 0, nfail = 0, cyc = 0;
    bit  chk_en = 1'b1;
    int  hist [MAXT];
    int  hk [MAXT/2];
    int  n_t = 1, d_f = 1, byp = 0, ph = 0;
    int  due_q [$];
    int  val_q [$];
    string cur_req = "R4";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, longint act, longint exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                check({cur_req, " out_valid"}, out_valid, 1);
                check({cur_req, " out_data"}, $signed(out_data), val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end else begin
                check({cur_req, " idle out_valid"}, out_valid, 0);
            end
            check("R10 overrun low", overrun, 0);
        end
    end

    function automatic longint model_out();
        longint acc = 0, r;
        for (int i = 0; i < n_t; i++) begin
            int j = (i < n_t - 1 - i) ? i : n_t - 1 - i;
            acc += longint'(hk[j]) * longint'(hist[i]);
        end
        r = (acc + (64'sd1 <<< 14)) >>> 15;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(int n, int d, int b);
        wr(0, n); wr(1, d - 1); wr(2, b);
        n_t = n; d_f = d; byp = b;
    endtask

    task automatic wcoef(int idx, int v);
        wr(64 + idx, v & 16'hffff);
        wr(96 + idx, (v >>> 16) & 15);
        hk[idx] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        due_q.delete(); val_q.delete();
        foreach (hist[i]) hist[i] = 0;
        ph = 0; n_t = 1; d_f = 1; byp = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(int x, int gap);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(x);
        if (byp != 0) begin
            due_q.push_back(cyc + 1);
            val_q.push_back(x);
        end else begin
            for (int i = MAXT - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = x;
            ph++;
            if (ph == d_f) begin
                ph = 0;
                due_q.push_back(cyc + (n_t + 1) / 2 + 2);
                val_q.push_back(int'(model_out()));
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    function automatic int samp(int i, int s);
        return ((i * s) % 60001) - 30000;
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset overrun", overrun, 0);
        check("R1 reset out_data", out_data, 0);

        for (int k = 0; k < MAXT/2; k++) wcoef(k, ((k * 7919) % 4001) - 2000);

        // R4/R5: odd tap count, centre tap alone, no decimation
        cur_req = "R5 odd";
        set_cfg(7, 1, 0);
        for (int i = 0; i < 20; i++) push(samp(i, 1237), 8);

        // R5/R6: even tap count, decimate by 3
        cur_req = "R6 even D3";
        do_reset(); set_cfg(8, 3, 0);
        for (int i = 0; i < 24; i++) push(samp(i, 4513), 8);

        // R4/R6/R7: full length, decimate by 16
        cur_req = "R7 N64 D16";
        do_reset(); set_cfg(64, 16, 0);
        for (int i = 0; i < 48; i++) push(samp(i, 977), 36);

        // R8: saturation in both directions
        cur_req = "R8 saturate";
        do_reset();
        for (int k = 0; k < MAXT/2; k++) wcoef(k, 524287);
        set_cfg(64, 1, 0);
        for (int i = 0; i < 66; i++) push(32767, 36);
        for (int i = 0; i < 66; i++) push(-32768, 36);
        for (int k = 0; k < MAXT/2; k++) wcoef(k, ((k * 4441) % 3001) - 1500);

        // R9: bypass leaves delay line and phase untouched
        cur_req = "R9 bypass";
        do_reset(); set_cfg(5, 2, 0);
        for (int i = 0; i < 3; i++) push(samp(i, 3301), 6);
        wr(2, 1); byp = 1;
        for (int i = 0; i < 4; i++) push(samp(i + 9, 2203), 3);
        push(-32768, 3);
        wr(2, 0); byp = 0;
        for (int i = 0; i < 6; i++) push(samp(i + 3, 3301), 6);

        // R2: low word alone does not commit, high word does
        cur_req = "R2 commit";
        do_reset(); set_cfg(3, 1, 0);
        wr(64, 16'h1234);
        for (int i = 0; i < 5; i++) push(samp(i, 555), 6);
        wr(96, 16'h000f);
        hk[0] = -((1 << 20) - 32'h000f1234);
        for (int i = 0; i < 5; i++) push(samp(i, 919), 6);

        // R1: coefficients survive reset, config returns to defaults
        cur_req = "R1 retain";
        do_reset();
        for (int i = 0; i < 3; i++) push(samp(i, 711), 6);
        set_cfg(6, 2, 0);
        for (int i = 0; i < 10; i++) push(samp(i, 1811), 8);

        // R10: samples faster than the engine set sticky overrun
        repeat (40) @(negedge clk);
        chk_en = 1'b0;
        do_reset(); set_cfg(64, 1, 0);
        for (int i = 0; i < 4; i++) push(samp(i, 100), 2);
        repeat (3) @(negedge clk);
        check("R10 overrun set", overrun, 1);
        repeat (80) @(negedge clk);
        check("R10 overrun sticky", overrun, 1);
        do_reset();
        @(negedge clk);
        check("R10 overrun cleared by reset (R1)", overrun, 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule